// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block sits between an 8-bit controller core and its external memory pins. It turns each core request into one bus slot, counted in oscillator clocks. A request can be an instruction fetch, a data read or a data write. Each slot drives the address-latch strobe, an active-low program-store strobe, active-low read and write strobes, a multiplexed low-address/data port and a high-address port.

Fetch slots and idle slots each last half a machine cycle, which is 6 clocks. A data access takes a full machine cycle of 12 clocks. In that slot the latch strobe pulses once instead of twice, and the program-store strobe does not pulse at all. A control bit can hold the latch strobe high through fetch and idle slots, which stops its emissions while only internal code runs. A data access that gives only an 8-bit address puts the contents of a port register on the high port instead of an address byte.

Requests use a valid/ready handshake. `req_ready` is high only in the last clock of the current slot, and a request is taken on the rising edge where both signals are high. The core must hold its fields stable while `req_valid` is high and `req_ready` is low. Responses carry no back-pressure: `rsp_valid` is a one-clock pulse that the core must take when it appears.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is held and directly after it: `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `p0_oe`=0, `p2_out`=0xFF, `req_ready`=1 and `rsp_valid`=0. The latch-disable bit is 0.
- R2: `req_ready` is 1 only in the last clock of a slot. A request presented in the first clock of an idle slot is held off for exactly five clocks. The slot for an accepted request starts at clock 0 in the next clock.
- R3: A fetch slot (`req_is_code`=1) lasts 6 clocks. In it, `ale`=1 in clocks 0-1, `p0_out`=addr[7:0] with `p0_oe`=1 in clocks 0-2, and `psen_n`=0 with `p0_oe`=0 in clocks 3-5. `p2_out`=addr[15:8] throughout, whatever the values of `req_is_write` and `req_use8`.
- R4: With no request, idle slots of 6 clocks repeat. In each, `ale`=1 in clocks 0-1, all strobes are high, `p0_oe`=0, and `p2_out` shows the port register. The latch strobe therefore pulses once every 6 clocks.
- R5: A data slot lasts 12 clocks. `ale`=1 only in clocks 0-1, and `psen_n` stays 1. `rd_n` (read) or `wr_n` (write) is 0 in clocks 4-9, which is 6 clocks.
- R6: On a write, `p0_out`=wdata with `p0_oe`=1 in clocks 3-10, and `p0_oe`=0 in clock 11.
- R7: On a read, `p0_oe`=0 from clock 3 to clock 11. `p0_in` is sampled at the edge that ends clock 9 of a read slot, or clock 5 of a fetch slot.
- R8: `rsp_valid` is high for one clock, in the clock after the last clock of a fetch or data slot, and never after an idle slot. It comes with the sampled byte on `rsp_rdata`. After a write, `rsp_rdata` keeps its previous value.
- R9: During a data slot, `p2_out`=addr[15:8] when `req_use8`=0 and the port register when `req_use8`=1.
- R10: A control write to address 0x8E sets the latch-disable bit from bit 0 of the written data. While the bit is 1, `ale` stays 1 through every clock of fetch and idle slots, and data slots still pulse it in clocks 0-1.
- R11: A control write to address 0xA0 loads the port register, whose reset value is 0xFF. A control write to any other address changes neither the port register nor the latch-disable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this clock if valid |
| req_is_code | input | 1 | 1 = instruction fetch |
| req_is_write | input | 1 | 1 = data write (data requests only) |
| req_use8 | input | 1 | 1 = data access with an 8-bit address |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte sampled from the bus |
| sfr_wr | input | 1 | Control register write strobe |
| sfr_addr | input | 8 | Control register address |
| sfr_wdata | input | 8 | Control register write data |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Multiplexed address/data out |
| p0_oe | output | 1 | Drive enable for p0_out |
| p0_in | input | 8 | Multiplexed port input |
| p2_out | output | 8 | High address / port register out |

## Verification
The assertions assume that `req_valid` and the request fields are known whenever the block is out of reset. They also assume that control writes are single-clock pulses. The bench holds each request steady until its handshake completes and gives every control write one clock. It changes `p0_in` only at falling edges, and it puts the expected byte on `p0_in` only in the clock that should be sampled. That makes an early or late sample visible on `rsp_rdata`.

// File: rtl/ext_bus_seq_pkg.sv
package ext_bus_seq_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_CODE = 2'd1,
    SLOT_RD   = 2'd2,
    SLOT_WR   = 2'd3
  } slot_e;

  function automatic logic slot_is_data(slot_e k);
    return (k == SLOT_RD) || (k == SLOT_WR);
  endfunction

endpackage

// File: rtl/ext_bus_seq_sfr.sv
module ext_bus_seq_sfr #(
  parameter int          SFR_AW   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  AUX_ADDR = 8'h8E,
  parameter logic [7:0]  P2_ADDR  = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic              ale_off,
  output logic [DATA_W-1:0] p2_reg
);

  localparam logic [SFR_AW-1:0] AUX_A = SFR_AW'(AUX_ADDR);
  localparam logic [SFR_AW-1:0] P2_A  = SFR_AW'(P2_ADDR);

  logic hit_aux, hit_p2;
  assign hit_aux = sfr_wr && (sfr_addr == AUX_A);
  assign hit_p2  = sfr_wr && (sfr_addr == P2_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_off <= 1'b0;
      p2_reg  <= '1;
    end else begin
      if (hit_aux) ale_off <= sfr_wdata[0];
      if (hit_p2)  p2_reg  <= sfr_wdata;
    end
  end

  // R10
  aux_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == AUX_A) |=> (ale_off == $past(sfr_wdata[0])));

  // R11
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr != AUX_A && sfr_addr != P2_A) |=> ($stable(ale_off) && $stable(p2_reg)));

endmodule

// File: rtl/ext_bus_seq_slot.sv
module ext_bus_seq_slot
  import ext_bus_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int FETCH_LEN = 6,
  parameter int DATA_LEN  = 12,
  parameter int TW        = $clog2(DATA_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_code,
  input  logic              req_is_write,
  input  logic              req_use8,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output slot_e             kind,
  output logic [TW-1:0]     tick,
  output logic              slot_last,
  output logic              use8,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);

  localparam logic [TW-1:0] LAST_HALF = TW'(FETCH_LEN - 1);
  localparam logic [TW-1:0] LAST_FULL = TW'(DATA_LEN - 1);

  logic [TW-1:0] last_tick;
  slot_e         next_kind;

  assign last_tick = slot_is_data(kind) ? LAST_FULL : LAST_HALF;
  assign slot_last = (tick == last_tick);
  assign req_ready = slot_last;

  always_comb begin
    if (req_is_code)       next_kind = SLOT_CODE;
    else if (req_is_write) next_kind = SLOT_WR;
    else                   next_kind = SLOT_RD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind  <= SLOT_IDLE;
      tick  <= LAST_HALF;
      use8  <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else if (slot_last) begin
      tick <= '0;
      if (req_valid) begin
        kind  <= next_kind;
        use8  <= req_use8 & ~req_is_code;
        addr  <= req_addr;
        wdata <= req_wdata;
      end else begin
        kind <= SLOT_IDLE;
      end
    end else begin
      tick <= tick + 1'b1;
    end
  end

  // R2
  slot_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != $past(kind)) |-> $past(slot_last));

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (tick == '0 && kind != SLOT_IDLE));

endmodule

// File: rtl/ext_bus_seq_drv.sv
module ext_bus_seq_drv
  import ext_bus_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int TW         = 4,
  parameter int ALE_W      = 2,
  parameter int ADDR_HOLD  = 1,
  parameter int CODE_STB   = 3,
  parameter int DATA_SETUP = 1,
  parameter int DATA_STB   = 6,
  parameter int DATA_HOLD  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_e             kind,
  input  logic [TW-1:0]     tick,
  input  logic              slot_last,
  input  logic              use8,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ale_off,
  input  logic [DATA_W-1:0] p2_reg,
  input  logic [DATA_W-1:0] p0_in,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [DATA_W-1:0] p2_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int ADDR_END_I = ALE_W + ADDR_HOLD;
  localparam int DSTB_LO_I  = ADDR_END_I + DATA_SETUP;
  localparam int DSTB_HI_I  = DSTB_LO_I + DATA_STB - 1;

  localparam logic [TW-1:0] T_ALE_END  = TW'(ALE_W);
  localparam logic [TW-1:0] T_ADDR_END = TW'(ADDR_END_I);
  localparam logic [TW-1:0] T_CSTB_HI  = TW'(ADDR_END_I + CODE_STB - 1);
  localparam logic [TW-1:0] T_DSTB_LO  = TW'(DSTB_LO_I);
  localparam logic [TW-1:0] T_DSTB_HI  = TW'(DSTB_HI_I);
  localparam logic [TW-1:0] T_WDAT_HI  = TW'(DSTB_HI_I + DATA_HOLD);
  localparam int            RUN_W      = TW + 1;

  logic is_data, in_ale, in_addr, in_cstb, in_dstb, in_wdat, sample;

  assign is_data = slot_is_data(kind);
  assign in_ale  = (tick < T_ALE_END);
  assign in_addr = (tick < T_ADDR_END);
  assign in_cstb = (tick >= T_ADDR_END) && (tick <= T_CSTB_HI);
  assign in_dstb = (tick >= T_DSTB_LO) && (tick <= T_DSTB_HI);
  assign in_wdat = (tick >= T_ADDR_END) && (tick <= T_WDAT_HI);

  // Latch strobe: data slots always pulse; other slots pulse unless held high.
  assign ale = is_data ? in_ale : (ale_off | in_ale);

  assign psen_n = !((kind == SLOT_CODE) && in_cstb);
  assign rd_n   = !((kind == SLOT_RD) && in_dstb);
  assign wr_n   = !((kind == SLOT_WR) && in_dstb);

  assign p0_oe  = ((kind != SLOT_IDLE) && in_addr) || ((kind == SLOT_WR) && in_wdat);
  assign p0_out = in_addr ? addr[DATA_W-1:0] : wdata;

  assign p2_out = ((kind == SLOT_IDLE) || (is_data && use8)) ? p2_reg
                                                             : addr[ADDR_W-1 -: DATA_W];

  assign sample = ((kind == SLOT_CODE) && (tick == T_CSTB_HI)) ||
                  ((kind == SLOT_RD)   && (tick == T_DSTB_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= slot_last && (kind != SLOT_IDLE);
      if (sample) rsp_rdata <= p0_in;
    end
  end

  // Strobe run-length tracking for the width checks.
  logic [RUN_W-1:0] rd_run, wr_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run <= '0;
      wr_run <= '0;
    end else begin
      rd_run <= rd_n ? '0 : rd_run + 1'b1;
      wr_run <= wr_n ? '0 : wr_run + 1'b1;
    end
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  // R5
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (rd_run == RUN_W'(DATA_STB)));

  // R5
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (wr_run == RUN_W'(DATA_STB)));

  // R7
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !p0_oe);

  // R6
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (p0_oe && p0_out == wdata));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  p2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data && tick != '0) |-> $stable(p2_out));

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_seq_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         DATA_W     = 8,
  parameter int         SFR_AW     = 8,
  parameter int         ALE_W      = 2,
  parameter int         ADDR_HOLD  = 1,
  parameter int         CODE_STB   = 3,
  parameter int         DATA_SETUP = 1,
  parameter int         DATA_STB   = 6,
  parameter int         DATA_HOLD  = 1,
  parameter logic [7:0] AUX_ADDR   = 8'h8E,
  parameter logic [7:0] P2_ADDR    = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_code,
  input  logic              req_is_write,
  input  logic              req_use8,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              sfr_wr,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  input  logic [DATA_W-1:0] p0_in,
  output logic [DATA_W-1:0] p2_out
);

  localparam int FETCH_LEN = ALE_W + ADDR_HOLD + CODE_STB;
  localparam int DATA_LEN  = 2 * FETCH_LEN;
  localparam int TW        = $clog2(DATA_LEN);

  initial begin
    if (ALE_W + ADDR_HOLD + DATA_SETUP + DATA_STB + DATA_HOLD >= DATA_LEN)
      $error("data strobe window does not fit in a machine cycle");
  end

  slot_e             kind;
  logic [TW-1:0]     tick;
  logic              slot_last, use8, ale_off;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, p2_reg;

  ext_bus_seq_sfr #(
    .SFR_AW(SFR_AW), .DATA_W(DATA_W), .AUX_ADDR(AUX_ADDR), .P2_ADDR(P2_ADDR)
  ) u_sfr (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .ale_off(ale_off), .p2_reg(p2_reg)
  );

  ext_bus_seq_slot #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FETCH_LEN(FETCH_LEN),
    .DATA_LEN(DATA_LEN), .TW(TW)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_code(req_is_code),
    .req_is_write(req_is_write), .req_use8(req_use8), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .kind(kind), .tick(tick),
    .slot_last(slot_last), .use8(use8), .addr(addr), .wdata(wdata)
  );

  ext_bus_seq_drv #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TW(TW), .ALE_W(ALE_W),
    .ADDR_HOLD(ADDR_HOLD), .CODE_STB(CODE_STB), .DATA_SETUP(DATA_SETUP),
    .DATA_STB(DATA_STB), .DATA_HOLD(DATA_HOLD)
  ) u_drv (
    .clk(clk), .rst_n(rst_n), .kind(kind), .tick(tick), .slot_last(slot_last),
    .use8(use8), .addr(addr), .wdata(wdata), .ale_off(ale_off), .p2_reg(p2_reg),
    .p0_in(p0_in), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

endmodule

// File: tb/ext_bus_seq_tb.sv
module ext_bus_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int K_IDLE = 0, K_CODE = 1, K_RD = 2, K_WR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_code = 1'b0, req_is_write = 1'b0, req_use8 = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic sfr_wr = 1'b0;
  logic [7:0] sfr_addr = '0, sfr_wdata = '0;
  logic [7:0] p0_in = '0;
  logic req_ready, rsp_valid, ale, psen_n, rd_n, wr_n, p0_oe;
  logic [7:0] rsp_rdata, p0_out, p2_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_rdata = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_code(req_is_code), .req_is_write(req_is_write), .req_use8(req_use8),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out)
  );

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Checks one slot starting at the falling edge inside clock 0.
  task automatic check_slot(input int k, input logic use8, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] p2v,
                            input logic aoff, input logic [7:0] good);
    int len  = (k >= K_RD) ? 12 : 6;
    int samp = (k == K_CODE) ? 5 : 9;
    string tg = (k == K_IDLE) ? "R4" : (k == K_CODE) ? "R3" : "R5";
    for (int t = 0; t < len; t++) begin
      logic e_ale, e_oe;
      logic [7:0] e_p2;
      p0_in = (t == samp) ? good : ~good;
      e_ale = (k >= K_RD) ? (t < 2) : (aoff ? 1'b1 : (t < 2));
      e_oe  = (k != K_IDLE && t < 3) || (k == K_WR && t >= 3 && t <= 10);
      e_p2  = (k == K_IDLE || (k >= K_RD && use8)) ? p2v : a[15:8];
      chk(aoff ? "R10" : tg, "ale", 16'(ale), 16'(e_ale));
      chk(tg, "psen_n", 16'(psen_n), 16'(!(k == K_CODE && t >= 3)));
      chk(tg, "rd_n", 16'(rd_n), 16'(!(k == K_RD && t >= 4 && t <= 9)));
      chk(tg, "wr_n", 16'(wr_n), 16'(!(k == K_WR && t >= 4 && t <= 9)));
      chk((k == K_WR) ? "R6" : "R7", "p0_oe", 16'(p0_oe), 16'(e_oe));
      if (e_oe) chk((t < 3) ? tg : "R6", "p0_out", 16'(p0_out), 16'((t < 3) ? a[7:0] : wd));
      chk((k >= K_RD) ? "R9" : tg, "p2_out", 16'(p2_out), 16'(e_p2));
      chk("R2", "req_ready", 16'(req_ready), 16'(t == len - 1));
      if (t < len - 1) @(negedge clk);
    end
    @(negedge clk);
    chk("R8", "rsp_valid", 16'(rsp_valid), 16'(k != K_IDLE));
    if (k == K_CODE || k == K_RD) last_rdata = good;
    if (k != K_IDLE) chk((k == K_WR) ? "R8" : "R7", "rsp_rdata", 16'(rsp_rdata), 16'(last_rdata));
  endtask

  task automatic do_access(input int k, input logic use8, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] p2v,
                           input logic aoff, input logic [7:0] good);
    req_is_code  = (k == K_CODE);
    req_is_write = (k == K_WR) || (k == K_CODE && use8);
    req_use8     = use8;
    req_addr     = a;
    req_wdata    = wd;
    req_valid    = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check_slot(k, use8, a, wd, p2v, aoff, good);
  endtask

  task automatic idle_slot(input logic [7:0] p2v, input logic aoff);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    check_slot(K_IDLE, 1'b0, 16'h0000, 8'h00, p2v, aoff, 8'h00);
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  // R2: a request raised in clock 0 of an idle slot waits five clocks.
  task automatic test_backpressure();
    int waits = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_is_code = 1'b1; req_is_write = 1'b0; req_use8 = 1'b0;
    req_addr = 16'h2468; req_valid = 1'b1;
    while (!req_ready) begin
      waits++;
      @(negedge clk);
    end
    chk("R2", "wait clocks", 16'(waits), 16'd5);
    @(negedge clk);
    req_valid = 1'b0;
    check_slot(K_CODE, 1'b0, 16'h2468, 8'h00, 8'h5A, 1'b0, 8'h77);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1", "ale", 16'(ale), 16'd0);
    chk("R1", "strobes", 16'({psen_n, rd_n, wr_n}), 16'h7);
    chk("R1", "p0_oe", 16'(p0_oe), 16'd0);
    chk("R1", "p2_out", 16'(p2_out), 16'hFF);
    chk("R1", "req_ready", 16'(req_ready), 16'd1);
    chk("R1", "rsp_valid", 16'(rsp_valid), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    idle_slot(8'hFF, 1'b0);                                            // R4
    idle_slot(8'hFF, 1'b0);                                            // R4
    do_access(K_CODE, 1'b0, 16'h1234, 8'h00, 8'hFF, 1'b0, 8'hA5);      // R3 R7 R8, R1 latch enabled
    do_access(K_CODE, 1'b1, 16'hBEEF, 8'h11, 8'hFF, 1'b0, 8'hC3);      // R3 ignores write/use8
    do_access(K_RD,   1'b0, 16'h4321, 8'h00, 8'hFF, 1'b0, 8'h3C);      // R5 R7 R9
    do_access(K_WR,   1'b0, 16'h8001, 8'h96, 8'hFF, 1'b0, 8'h00);      // R5 R6 R8
    sfr_write(8'hA0, 8'h5A);                                           // R11
    idle_slot(8'h5A, 1'b0);                                            // R11 R4
    do_access(K_RD,   1'b1, 16'h7777, 8'h00, 8'h5A, 1'b0, 8'h81);      // R9
    do_access(K_WR,   1'b1, 16'h0F0F, 8'h42, 8'h5A, 1'b0, 8'h00);      // R9 R6
    sfr_write(8'h8F, 8'h01);                                           // R11 ignored address
    sfr_write(8'hA1, 8'h00);                                           // R11 ignored address
    do_access(K_CODE, 1'b0, 16'h3300, 8'h00, 8'h5A, 1'b0, 8'h18);      // R11 latch still pulses
    sfr_write(8'h8E, 8'h01);                                           // R10
    do_access(K_CODE, 1'b0, 16'h5501, 8'h00, 8'h5A, 1'b1, 8'hE7);      // R10 held high
    idle_slot(8'h5A, 1'b1);                                            // R10
    do_access(K_RD,   1'b0, 16'hABCD, 8'h00, 8'h5A, 1'b1, 8'h66);      // R10 data still pulses
    sfr_write(8'h8E, 8'h00);                                           // R10 re-enable
    do_access(K_CODE, 1'b0, 16'h0102, 8'h00, 8'h5A, 1'b0, 8'h99);      // R10
    test_backpressure();                                               // R2
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule